// File: doc/BRIEF.md
# Masked Data Breakpoint Comparator

This block watches the data phase of a 32-bit processor local bus and produces a breakpoint trigger when a bus cycle carries a programmed data pattern. Two 32-bit registers set the pattern: a value register and a mask register. Debug software reaches them through a small register port that selects a register with a 5-bit index. That port only works while a privilege input is high.

For each valid bus cycle, the block uses the two low address bits and the access size to work out which byte lanes hold the operand. It compares only those lanes against the value register and skips every bit whose mask bit is set. A reference that crosses a word boundary arrives as several bus cycles. Each of those cycles is judged on its own.

Top module: `dbrk_data_match`

## Requirements
- R1: With `priv` high, a read at index 0x0E returns the value register and a read at index 0x0F returns the mask register. A read at any other index returns zero. Reads are combinational.
- R2: A register write takes effect at the next clock edge. A bus cycle presented in the same cycle as the write is compared against the old contents.
- R3: A mask bit of 1 excludes the matching bit from the comparison. A mask bit of 0 requires the bus bit to equal the value bit in the same position.
- R4: For a byte access (`bus_size` = 2'b01), address bits 2'b00, 2'b01, 2'b10 and 2'b11 select D[31:24], D[23:16], D[15:8] and D[7:0] respectively.
- R5: For a word access (`bus_size` = 2'b10), `bus_addr_lo[1]` = 0 selects D[31:16] and `bus_addr_lo[1]` = 1 selects D[15:0]. `bus_addr_lo[0]` is ignored.
- R6: A longword access (`bus_size` = 2'b00) compares all of D[31:0] whatever the address bits are. The unused code 2'b11 is also treated as a longword.
- R7: `trig` is low after reset. It is high for exactly the cycle after a clock edge at which `bus_valid` was high and every unmasked bit of every active lane matched. At every other time it is low.
- R8: Bus data bits outside the active operand lanes never affect the match.
- R9: While `priv` is low, register writes are ignored and both registers keep their contents.
- R10: While `priv` is low, `reg_rdata` is zero.
- R11: Back-to-back bus cycles, such as the pieces of a misaligned reference, are each checked on their own. Every matching cycle produces its own trigger cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the trigger only |
| priv | input | 1 | Supervisor/debug privilege; enables register access |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 5 | Debug register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | A bus data cycle is present |
| bus_addr_lo | input | 2 | Low address bits of the bus cycle |
| bus_size | input | 2 | Access size: 00 long, 01 byte, 10 word, 11 long |
| bus_data | input | 32 | Bus data word |
| trig | output | 1 | Registered breakpoint trigger pulse |

## Verification
The timing of each result is fixed:
- The trigger answer to a bus cycle sampled at one rising edge is due one clock later. The bench drives each bus cycle on a falling edge and reads `trig` at the next falling edge.
- Reads are combinational. They are checked 1 ns after the index is driven, inside the same cycle.
- A write shows up in the registers only after the following rising edge. Read-back and match checks that depend on a write therefore come one cycle after it.

A behavioural model in the bench updates its register copies and its expected trigger on every rising edge. Every falling edge compares `trig` against that model.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
   typedef enum logic [1:0] {
      ACC_LONG = 2'b00,
      ACC_BYTE = 2'b01,
      ACC_WORD = 2'b10,
      ACC_RSVD = 2'b11
   } acc_size_e;
endpackage

// File: rtl/dbrk_regs.sv
module dbrk_regs #(
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 5,
   parameter int VAL_IDX = 14,
   parameter int MSK_IDX = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              priv,
   input  logic              wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] val_q,
   output logic [DATA_W-1:0] mask_q
);
   localparam logic [IDX_W-1:0] VAL_SEL = IDX_W'(VAL_IDX);
   localparam logic [IDX_W-1:0] MSK_SEL = IDX_W'(MSK_IDX);

   generate
      if (VAL_IDX == MSK_IDX) begin : g_bad_idx
         $error("value and mask indices must differ");
      end
      if (VAL_IDX >= (1 << IDX_W) || MSK_IDX >= (1 << IDX_W)) begin : g_bad_range
         $error("register index does not fit IDX_W");
      end
   endgenerate

   logic wr_ok;
   assign wr_ok = priv & wr;

   // The pattern registers have no defined reset value.
   always_ff @(posedge clk) begin
      if (wr_ok && idx == VAL_SEL) val_q  <= wdata;
      if (wr_ok && idx == MSK_SEL) mask_q <= wdata;
   end

   always_comb begin
      rdata = '0;
      if (priv) begin
         if (idx == VAL_SEL)      rdata = val_q;
         else if (idx == MSK_SEL) rdata = mask_q;
      end
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (priv && wr && idx == VAL_SEL) |=> (val_q == $past(wdata))); // R2
   AST_NOPRIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!priv) |=> ($stable(val_q) && $stable(mask_q))); // R9
endmodule

// File: rtl/dbrk_lane_sel.sv
module dbrk_lane_sel
   import dbrk_pkg::*;
#(
   parameter int LANES = 4,
   localparam int AW   = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr_lo,
   input  logic [1:0]       size,
   output logic [LANES-1:0] lane_en
);
   generate
      if (LANES < 4 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("LANES must be a power of two, at least 4");
      end
   endgenerate

   // Lane i carries bits [8i+7:8i]. The lowest address maps to the most significant lane.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic byte_hit;
      logic word_hit;
      assign byte_hit = (addr_lo == AW'(LANES - 1 - i));
      assign word_hit = (addr_lo[AW-1:1] == (AW-1)'((LANES - 1 - i) >> 1));
      always_comb begin
         unique case (acc_size_e'(size))
            ACC_BYTE: lane_en[i] = byte_hit;
            ACC_WORD: lane_en[i] = word_hit;
            default:  lane_en[i] = 1'b1;
         endcase
      end
   end

   AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lane_en) == ((size == 2'b01) ? 1 : (size == 2'b10) ? 2 : LANES)); // R6
endmodule

// File: rtl/dbrk_lane_cmp.sv
module dbrk_lane_cmp #(
   parameter int LANES  = 4,
   localparam int DATA_W = LANES * 8
) (
   input  logic [DATA_W-1:0] bus_data,
   input  logic [DATA_W-1:0] val,
   input  logic [DATA_W-1:0] mask,
   input  logic [LANES-1:0]  lane_en,
   output logic              hit
);
   logic [LANES-1:0] lane_ok;

   for (genvar i = 0; i < LANES; i++) begin : g_cmp
      logic [7:0] diff;
      assign diff       = (bus_data[8*i +: 8] ^ val[8*i +: 8]) & ~mask[8*i +: 8];
      assign lane_ok[i] = ~lane_en[i] | ~(|diff);
   end

   assign hit = &lane_ok;
endmodule

// File: rtl/dbrk_data_match.sv
module dbrk_data_match #(
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 5,
   parameter int VAL_IDX = 14,
   parameter int MSK_IDX = 15,
   localparam int LANES  = DATA_W / 8,
   localparam int AW     = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              priv,
   input  logic              reg_wr,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              bus_valid,
   input  logic [AW-1:0]     bus_addr_lo,
   input  logic [1:0]        bus_size,
   input  logic [DATA_W-1:0] bus_data,
   output logic              trig
);
   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
   endgenerate

   logic [DATA_W-1:0] val_q;
   logic [DATA_W-1:0] mask_q;
   logic [LANES-1:0]  lane_en;
   logic              hit;
   logic              trig_q;

   dbrk_regs #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .VAL_IDX(VAL_IDX),
      .MSK_IDX(MSK_IDX)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .priv  (priv),
      .wr    (reg_wr),
      .idx   (reg_idx),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .val_q (val_q),
      .mask_q(mask_q)
   );

   dbrk_lane_sel #(.LANES(LANES)) u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr_lo(bus_addr_lo),
      .size   (bus_size),
      .lane_en(lane_en)
   );

   dbrk_lane_cmp #(.LANES(LANES)) u_cmp (
      .bus_data(bus_data),
      .val     (val_q),
      .mask    (mask_q),
      .lane_en (lane_en),
      .hit     (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= bus_valid & hit;
   end

   assign trig = trig_q;

   AST_TRIG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> $past(bus_valid)); // R7
   AST_FULL_MASK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && (&mask_q)) |=> trig); // R3
   AST_NOPRIV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!priv) |-> (reg_rdata == '0)); // R10
endmodule

// File: tb/dbrk_data_match_tb.sv
`timescale 1ns/1ps
module dbrk_data_match_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        priv = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        bus_valid = 1'b0;
   logic [1:0]  bus_addr_lo = '0;
   logic [1:0]  bus_size = '0;
   logic [31:0] bus_data = '0;
   logic        trig;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dbrk_data_match u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .priv       (priv),
      .reg_wr     (reg_wr),
      .reg_idx    (reg_idx),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .bus_valid  (bus_valid),
      .bus_addr_lo(bus_addr_lo),
      .bus_size   (bus_size),
      .bus_data   (bus_data),
      .trig       (trig)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   logic [31:0] m_val, m_mask;
   bit          m_trig = 1'b0;

   function automatic logic [31:0] lanes_of(input logic [1:0] a, input logic [1:0] sz);
      case (sz)
         2'b01:   return 32'hFF00_0000 >> (8 * a);
         2'b10:   return a[1] ? 32'h0000_FFFF : 32'hFFFF_0000;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) m_trig = 1'b0;
      else begin
         m_trig = bus_valid &&
                  (((bus_data ^ m_val) & ~m_mask & lanes_of(bus_addr_lo, bus_size)) == 32'h0);
         if (priv && reg_wr && reg_idx == 5'h0E) m_val  = reg_wdata;
         if (priv && reg_wr && reg_idx == 5'h0F) m_mask = reg_wdata;
      end
   end

   always @(negedge clk) begin
      if (rst_n) chk(trig === m_trig, "R7 model", {31'b0, trig}, {31'b0, m_trig});
   end

   task automatic wreg(input logic [4:0] i, input logic [31:0] d);
      priv = 1'b1; reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input bit p, input logic [4:0] i, input logic [31:0] exp, input string req);
      priv = p; reg_idx = i;
      #1;
      chk(reg_rdata === exp, req, reg_rdata, exp);
   endtask

   task automatic bus(input logic [1:0] a, input logic [1:0] sz, input logic [31:0] d,
                      input bit exp, input string req);
      bus_valid = 1'b1; bus_addr_lo = a; bus_size = sz; bus_data = d;
      @(posedge clk); @(negedge clk);
      chk(trig === exp, req, {31'b0, trig}, {31'b0, exp});
   endtask

   task automatic idle();
      bus_valid = 1'b0;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(trig === 1'b0, "R7 reset", {31'b0, trig}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(trig === 1'b0, "R7 idle", {31'b0, trig}, 32'h0);

      wreg(5'h0E, 32'h1234_5678);
      wreg(5'h0F, 32'h0000_0000);
      rreg(1'b1, 5'h0E, 32'h1234_5678, "R1 value read");
      rreg(1'b1, 5'h0F, 32'h0000_0000, "R1 mask read");
      rreg(1'b1, 5'h0D, 32'h0000_0000, "R1 other index");

      // Longword
      bus(2'b10, 2'b00, 32'h1234_5678, 1'b1, "R6 long match");
      bus(2'b00, 2'b00, 32'h1234_5679, 1'b0, "R6 long miss");
      bus(2'b01, 2'b11, 32'h1234_5678, 1'b1, "R6 code 11 as long");
      idle();
      // Byte lanes
      bus(2'b00, 2'b01, 32'h12AA_AAAA, 1'b1, "R4 byte a0");
      bus(2'b01, 2'b01, 32'hBB34_BBBB, 1'b1, "R4 byte a1");
      bus(2'b10, 2'b01, 32'hCCCC_56CC, 1'b1, "R4 byte a2");
      bus(2'b11, 2'b01, 32'hDDDD_DD78, 1'b1, "R4 byte a3");
      bus(2'b11, 2'b01, 32'h1234_5677, 1'b0, "R4 byte a3 miss");
      bus(2'b00, 2'b01, 32'h1334_5678, 1'b0, "R4 byte a0 miss");
      bus(2'b00, 2'b01, 32'h1200_0000, 1'b1, "R8 outside lanes");
      idle();
      // Words
      bus(2'b00, 2'b10, 32'h1234_0000, 1'b1, "R5 word a0");
      bus(2'b01, 2'b10, 32'h1234_FFFF, 1'b1, "R5 word a1");
      bus(2'b10, 2'b10, 32'h0000_5678, 1'b1, "R5 word a2");
      bus(2'b11, 2'b10, 32'hFFFF_5678, 1'b1, "R5 word a3");
      bus(2'b10, 2'b10, 32'h1234_5600, 1'b0, "R5 word a2 miss");
      idle();
      // Masking
      wreg(5'h0F, 32'h0000_00FF);
      bus(2'b00, 2'b00, 32'h1234_56AA, 1'b1, "R3 masked byte ignored");
      bus(2'b00, 2'b00, 32'h1234_57AA, 1'b0, "R3 unmasked bit compared");
      idle();
      wreg(5'h0F, 32'hFFFF_FFFF);
      bus(2'b00, 2'b00, 32'h0000_0000, 1'b1, "R3 all masked");
      idle();
      wreg(5'h0F, 32'h0000_0000);
      // Misaligned pieces, back to back
      bus(2'b01, 2'b01, 32'h0034_0000, 1'b1, "R11 piece 1");
      bus(2'b10, 2'b10, 32'h0000_0000, 1'b0, "R11 piece 2");
      bus(2'b00, 2'b01, 32'h1200_0000, 1'b1, "R11 piece 3");
      idle();
      // Same-cycle write
      priv = 1'b1; reg_wr = 1'b1; reg_idx = 5'h0E; reg_wdata = 32'hCAFE_F00D;
      bus(2'b00, 2'b00, 32'h1234_5678, 1'b1, "R2 old value used");
      reg_wr = 1'b0;
      bus(2'b00, 2'b00, 32'hCAFE_F00D, 1'b1, "R2 new value used");
      bus(2'b00, 2'b00, 32'h1234_5678, 1'b0, "R2 old value gone");
      idle();
      // No privilege
      priv = 1'b0; reg_wr = 1'b1; reg_idx = 5'h0E; reg_wdata = 32'h0;
      @(posedge clk); @(negedge clk);
      reg_idx = 5'h0F;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
      rreg(1'b0, 5'h0E, 32'h0, "R10 read zero");
      bus(2'b00, 2'b00, 32'hCAFE_F00D, 1'b1, "R9 write ignored");
      rreg(1'b1, 5'h0E, 32'hCAFE_F00D, "R9 value kept");
      rreg(1'b1, 5'h0F, 32'h0000_0000, "R9 mask kept");
      // Valid low
      bus_valid = 1'b0; bus_data = 32'hCAFE_F00D; bus_size = 2'b00;
      @(posedge clk); @(negedge clk);
      chk(trig === 1'b0, "R7 no valid", {31'b0, trig}, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule